// File: doc/BRIEF.md
# Hybrid Coarse Delay Code Search Controller

This controller finds the 10-bit control code of a binary-weighted coarse delay line that is locked to a divided sensor clock. It has two phases. In the first, it runs a successive-approximation search over all ten bits, using a 1-bit early/late decision from a time comparator. The upper six bits are final when this search ends. The lower four bits also get a binary first guess. In the second phase, the controller watches the UP/DN outputs of a phase detector. While these disagree, the four-bit lower field moves up or down one step per evaluation, like a counter. Lock is declared once the detector has agreed for a programmable number of evaluations in a row.

A rising `start_go` pulse begins a search. `busy` is high while the controller works. `locked` is set when the search ends and stays high, with the code frozen, until the next accepted start. A larger code means more delay, so a faster input clock settles at a smaller code. Every trial and every evaluation waits `settle_len + 1` clock cycles so that the delay line and the comparators can respond before the result is used.

Top module: `coarse_code_search`

## Requirements
- R1: After reset, `code_o` is 0 and `busy`, `locked` and `range_err` are all 0.
- R2: A `start_go` sampled high while `busy` is 0 takes effect at the next edge. At that edge `busy` becomes 1, `locked` and `range_err` become 0, and `code_o` becomes 512 (only bit 9 set).
- R3: The binary search tries bits 9 down to 0 in that order. Each trial bit is held for `settle_len + 1` cycles. The bit is then cleared if `late` is 1 (1 means the delay is too long) and kept if `late` is 0, and the next lower bit is set for its trial. With a comparator that reports `late = (code > T)`, the code at the end of this search equals T.
- R4: After bit 0 is decided, the phase detector is evaluated once every `settle_len + 1` cycles. UP=1 with DN=0 adds one to bits 3:0. DN=1 with UP=0 subtracts one from bits 3:0. Bits 9:4 never change in this phase.
- R5: The lower field saturates at 15 and at 0 and never wraps. A step requested beyond either bound leaves the code unchanged and sets `range_err`. `range_err` then stays set until the next accepted start.
- R6: `locked` rises, and `busy` falls on the same edge, once UP equals DN for `lock_len` consecutive evaluations. A `lock_len` of 0 acts as 1. Any disagreement restarts this count. With no range error, a run lasts (10 + steps + `lock_len`) × (`settle_len` + 1) cycles from the start edge.
- R7: After lock, `locked` stays 1 and `code_o` stays fixed until the next accepted start, whatever the comparator and phase detector report.
- R8: A `start_go` pulse that arrives while `busy` is 1 is ignored. It does not change the code, the phase or the run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_go | input | 1 | Request to begin a new search |
| late | input | 1 | Time comparator decision; 1 means the current delay is too long |
| pd_up | input | 1 | Phase detector UP; asks for more delay |
| pd_dn | input | 1 | Phase detector DN; asks for less delay |
| settle_len | input | 4 | Extra wait cycles per trial or evaluation |
| lock_len | input | 4 | Consecutive agreements needed to lock (0 acts as 1) |
| code_o | output | 10 | Coarse delay control code |
| busy | output | 1 | Search in progress |
| locked | output | 1 | Search finished and code held |
| range_err | output | 1 | Lower field was pushed beyond a bound |

## Verification
The new trial code appears one edge after a start is accepted. Each decision then falls on every (`settle_len` + 1)-th edge after that, so the run length is known in advance: (10 + steps + `lock_len`) × (`settle_len` + 1) edges. The bench counts the falling clock edges at which `busy` is high and compares that count to the figure computed from the run's settings. It reads the code and the flags at a falling edge once `busy` has dropped. The delay line and both comparators are modelled as combinational functions of `code_o`, so each decision sees the code that has been held through its settle window. Checks after lock and after a range error are made at falling edges a fixed number of cycles later.

// File: rtl/coarse_code_search.sv
module coarse_code_search #(
  parameter int CODE_W = 10,
  parameter int LOW_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              late,
  input  logic              pd_up,
  input  logic              pd_dn,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic [CNT_W-1:0]  lock_len,
  output logic [CODE_W-1:0] code_o,
  output logic              busy,
  output logic              locked,
  output logic              range_err
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic              busy_q, lock_q, err_q, pd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  wait_q, agree_q, need;
  logic              tick, agree, at_top, at_bot;

  assign tick   = wait_q >= settle_len;
  assign need   = (lock_len == '0) ? CNT_W'(1) : lock_len;
  assign agree  = pd_up == pd_dn;
  assign at_top = code_q[LOW_W-1:0] == LOW_MAX;
  assign at_bot = code_q[LOW_W-1:0] == '0;

  assign code_o    = code_q;
  assign busy      = busy_q;
  assign locked    = lock_q;
  assign range_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      busy_q  <= 1'b0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
      pd_q    <= 1'b0;
      idx_q   <= '0;
      wait_q  <= '0;
      agree_q <= '0;
    end else if (!busy_q) begin
      if (start_go) begin
        code_q  <= '0;
        code_q[CODE_W-1] <= 1'b1;
        busy_q  <= 1'b1;
        lock_q  <= 1'b0;
        err_q   <= 1'b0;
        pd_q    <= 1'b0;
        idx_q   <= TOP_IDX;
        wait_q  <= '0;
        agree_q <= '0;
      end
    end else if (!tick) begin
      wait_q <= wait_q + 1'b1;
    end else begin
      wait_q <= '0;
      if (!pd_q) begin
        if (late) code_q[idx_q] <= 1'b0;
        if (idx_q == '0) begin
          pd_q <= 1'b1;
        end else begin
          code_q[idx_q - 1'b1] <= 1'b1;
          idx_q <= idx_q - 1'b1;
        end
      end else if (agree) begin
        agree_q <= agree_q + 1'b1;
        if (agree_q + 1'b1 >= need) begin
          lock_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end else begin
        agree_q <= '0;
        if (pd_up) begin
          if (at_top) err_q <= 1'b1;
          else code_q <= code_q + 1'b1;
        end else begin
          if (at_bot) err_q <= 1'b1;
          else code_q <= code_q - 1'b1;
        end
      end
    end
  end
endmodule

module coarse_code_search_chk #(
  parameter int CODE_W = 10,
  parameter int LOW_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_go,
  input logic [CODE_W-1:0] code,
  input logic              busy,
  input logic              lock,
  input logic              err,
  input logic              pd
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_go |=> busy && !lock && !err && code == (CODE_W'(1) << (CODE_W-1)));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pd && start_go |=> pd);

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pd |=> code[CODE_W-1:LOW_W] == $past(code[CODE_W-1:LOW_W]));

  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pd && code[LOW_W-1:0] == {LOW_W{1'b1}} |=> code[LOW_W-1:0] != '0);

  a_r5_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pd && code[LOW_W-1:0] == '0 |=> code[LOW_W-1:0] != {LOW_W{1'b1}});

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(!busy && start_go) |=> err);

  a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !start_go |=> lock && $stable(code));

  a_r6_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !busy);
endmodule

bind coarse_code_search coarse_code_search_chk #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_go(start_go), .code(code_q),
  .busy(busy_q), .lock(lock_q), .err(err_q), .pd(pd_q)
);

// File: tb/test_coarse_code_search.sv
`timescale 1ns/1ps
module test_coarse_code_search;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_go = 1'b0;
  logic [3:0] settle_len = 4'd0;
  logic [3:0] lock_len = 4'd1;
  logic [9:0] code_o;
  logic       busy, locked, range_err;
  logic       late, pd_up, pd_dn;

  int tgt_c = 0;
  int tgt_p = 0;
  logic force_agree = 1'b0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign late  = int'(code_o) > tgt_c;
  assign pd_up = !force_agree && int'(code_o) < tgt_p;
  assign pd_dn = !force_agree && int'(code_o) > tgt_p;

  coarse_code_search i_coarse_code_search (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .late(late),
    .pd_up(pd_up), .pd_dn(pd_dn), .settle_len(settle_len), .lock_len(lock_len),
    .code_o(code_o), .busy(busy), .locked(locked), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int run_len(input int steps, input int s, input int l);
    return (10 + steps + ((l == 0) ? 1 : l)) * (s + 1);
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_go = 1'b1;
    @(negedge clk); start_go = 1'b0;
  endtask

  // one lock run; inject>0 pulses start that many negedges into the run
  task automatic run(input int t, input int tp, input int s, input int l, input int inject, input string tag);
    int n;
    tgt_c = t; tgt_p = tp; force_agree = 1'b0;
    settle_len = 4'(s); lock_len = 4'(l);
    @(negedge clk); start_go = 1'b1;
    @(negedge clk); start_go = 1'b0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      if (n == inject) start_go = 1'b1;
      else start_go = 1'b0;
      @(negedge clk);
    end
    start_go = 1'b0;
    chk(n == run_len(absv(tp - t), s, l), {tag, " R6 run length"}, n, run_len(absv(tp - t), s, l));
    chk(code_o == 10'(tp), {tag, " R3/R4 final code"}, code_o, tp);
    chk(locked && !busy && !range_err, {tag, " R6 lock flags"}, {locked, busy, range_err}, 4);
  endtask

  initial begin
    int seed, t, k, s, l, lo;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(code_o == 0 && !busy && !locked && !range_err, "R1 reset", {code_o, busy, locked, range_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 start loads MSB trial
    tgt_c = 300; tgt_p = 300; settle_len = 4'd2; lock_len = 4'd2;
    pulse_start();
    chk(busy && !locked && code_o == 10'd512, "R2 start load", code_o, 512);
    while (busy) @(negedge clk);

    // directed: bounds of the code range, R3
    run(0, 0, 0, 1, 0, "d0");
    run(1023, 1023, 1, 3, 0, "d1023");
    run(917, 917, 0, 0, 0, "d917 lock_len0 R6");
    run(531, 534, 2, 2, 0, "d531 step up R4");
    run(168, 162, 1, 2, 0, "d168 step down R4");
    // R8 start while busy ignored (binary phase and counter phase)
    run(600, 603, 1, 2, 5, "R8 mid binary");
    run(600, 597, 0, 3, 13, "R8 mid counter");

    // R7 hold after lock
    tgt_c = 0; tgt_p = 1023;
    repeat (20) @(negedge clk);
    chk(locked && code_o == 10'd597, "R7 hold after lock", code_o, 597);

    // R5 saturation at top
    tgt_c = 1013; tgt_p = 1040; force_agree = 1'b0; settle_len = 4'd0; lock_len = 4'd2;
    pulse_start();
    for (int i = 0; i < 200 && !range_err; i++) @(negedge clk);
    chk(range_err && busy && !locked, "R5 top err", {range_err, busy, locked}, 6);
    chk(code_o == 10'd1023, "R5 top saturate", code_o, 1023);
    repeat (5) @(negedge clk);
    chk(code_o == 10'd1023 && range_err, "R5 top no wrap", code_o, 1023);
    force_agree = 1'b1;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk(locked && range_err && code_o == 10'd1023, "R5 err kept at lock", code_o, 1023);

    // R5 saturation at bottom, then R2 clears err
    tgt_c = 258; tgt_p = 200; force_agree = 1'b0;
    pulse_start();
    chk(!range_err && !locked, "R2 clears err", range_err, 0);
    for (int i = 0; i < 200 && !range_err; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(range_err && code_o == 10'd256, "R5 bottom saturate", code_o, 256);
    force_agree = 1'b1;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk(locked && code_o == 10'd256, "R5 bottom lock", code_o, 256);

    // constrained random runs
    for (int r = 0; r < 40; r++) begin
      t  = int'($urandom_range(1023, 0));
      k  = int'($urandom_range(6, 0)) - 3;
      lo = t % 16;
      if (lo + k < 0 || lo + k > 15) k = 0;
      s  = int'($urandom_range(3, 0));
      l  = int'($urandom_range(4, 0));
      run(t, t + k, s, l, 0, "rand R3 R4 R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule